// File: doc/BRIEF.md
# Shift-and-Add Sequential Multiplier

This block multiplies two unsigned `OPW`-bit operands into a `2*OPW`-bit product. It scans the multiplier one bit per clock. Each clock it adds a left-shifting copy of the multiplicand into an accumulator whenever the current low multiplier bit is set. A three-state controller has an idle/setup state, a compute state and a done state, and it talks to the user through a level start input and a done output.

In idle, the accumulator is cleared every cycle. While start is low, both operands are copied from the inputs every cycle. Raising start freezes the copies that were last captured and begins the computation. The computation stops as soon as the remaining multiplier bits are all zero, so a small multiplier finishes in fewer cycles. The product stays on the output, with done high, for as long as start is held. Dropping start returns the block to idle.

Top module: `shadd_mult`

## Requirements
- R1: While `rst_n` is low, `done` is 0 and `product` is 0, and the controller is in idle.
- R2: In idle, each clock edge loads 0 into the product register. If `start` is low at that edge, the edge also captures `op_a` (zero-extended to `2*OPW` bits) and `op_b`.
- R3: An edge in idle with `start` high moves the block to compute and captures no operands. Changes on `op_a`/`op_b` outside idle have no effect on the result.
- R4: At each compute edge where the remaining multiplier is non-zero, the product register gains the current multiplicand if the multiplier's bit 0 is 1, and keeps its value otherwise. On the same edge the multiplicand shifts left by one and the multiplier shifts right by one.
- R5: At a compute edge where the remaining multiplier is zero, the block moves to done and nothing else changes. `done` is therefore first seen high k+2 edges after `start` is raised in idle, where k is the index of the highest set bit of `op_b` plus one (k = 0 for `op_b` = 0).
- R6: `done` is high only in the done state. There, `product` equals `op_a * op_b` (the captured values) and stays stable.
- R7: In done, `done` stays high while `start` is 1. An edge with `start` at 0 returns the block to idle.
- R8: With operands 13 (1101) and 11 (1011), the product is 143 (10001111).
- R9: Zero and all-ones operands give exact products, for example `(2^OPW-1)^2` for two all-ones operands and 0 whenever either operand is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Level request: low loads operands, high runs and holds the result |
| op_a | input | OPW | Multiplicand |
| op_b | input | OPW | Multiplier |
| product | output | 2*OPW | Product register |
| done | output | 1 | High in the done state |

## Verification
A wrong bit in the multiplicand or multiplier register shows up as a wrong `product` on the clock edge after the next add that uses it. A wrong multiplier bit also shifts the cycle at which `done` rises, because termination depends on the register becoming zero. The bench runs a behavioural model of the registers and compares `product` and `done` on every clock. A fault therefore shows up within one cycle of reaching the output, not only when the final result is compared. A wrong controller state shows up at once as `done` being wrong, or as `product` failing to clear in idle.

// File: rtl/shadd_mult_pkg.sv
package shadd_mult_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_DONE = 2'd2
   } mult_state_t;

   // product register source select
   localparam logic PSRC_ZERO = 1'b0;
   localparam logic PSRC_SUM  = 1'b1;
endpackage

// File: rtl/shadd_shreg.sv
module shadd_shreg #(
   parameter int W       = 16,
   parameter bit GO_LEFT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   logic [W-1:0] q_next_shift;

   generate
      if (W < 1) begin : g_bad_width
         $error("shadd_shreg: W must be at least 1");
      end
      if (GO_LEFT) begin : g_left
         assign q_next_shift = {q[W-2:0], 1'b0};
      end else begin : g_right
         assign q_next_shift = {1'b0, q[W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (load) begin
         q <= din;
      end else if (shift) begin
         q <= q_next_shift;
      end
   end
endmodule

// File: rtl/shadd_accum.sv
module shadd_accum #(
   parameter int PW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          psel,
   input  logic          ep,
   input  logic [PW-1:0] addend,
   output logic [PW-1:0] p
);
   import shadd_mult_pkg::*;

   logic [PW:0]   sum_ext;
   logic [PW-1:0] p_src;

   assign sum_ext = {1'b0, p} + {1'b0, addend};
   assign p_src   = (psel == PSRC_SUM) ? sum_ext[PW-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p <= '0;
      end else if (ep) begin
         p <= p_src;
      end
   end

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ep && psel == PSRC_SUM) |-> !sum_ext[PW]); // R6
endmodule

// File: rtl/shadd_ctrl.sv
module shadd_ctrl
   import shadd_mult_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        b_zero,
   input  logic        b_lsb,
   output mult_state_t st,
   output logic        ld_ops,
   output logic        sh_ops,
   output logic        psel,
   output logic        ep,
   output logic        done
);
   mult_state_t st_nx;

   always_comb begin
      st_nx  = st;
      ld_ops = 1'b0;
      sh_ops = 1'b0;
      psel   = PSRC_ZERO;
      ep     = 1'b0;
      done   = 1'b0;
      unique case (st)
         ST_IDLE: begin
            ep = 1'b1;
            if (start) st_nx = ST_RUN;
            else       ld_ops = 1'b1;
         end
         ST_RUN: begin
            psel = PSRC_SUM;
            if (b_zero) begin
               st_nx = ST_DONE;
            end else begin
               sh_ops = 1'b1;
               ep     = b_lsb;
            end
         end
         ST_DONE: begin
            done = 1'b1;
            if (!start) st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_nx;
   end

   AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && b_zero) |=> done); // R5
   AST_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && start) |=> done); // R7
   AST_LEAVE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> (st == ST_IDLE)); // R7
endmodule

// File: rtl/shadd_mult.sv
module shadd_mult #(
   parameter int OPW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OPW-1:0]   op_a,
   input  logic [OPW-1:0]   op_b,
   output logic [2*OPW-1:0] product,
   output logic             done
);
   import shadd_mult_pkg::*;

   localparam int PW = 2 * OPW;

   generate
      if (OPW < 2) begin : g_bad_opw
         $error("shadd_mult: OPW must be at least 2");
      end
   endgenerate

   mult_state_t st;
   logic          ld_ops, sh_ops, psel, ep;
   logic [PW-1:0] a_q, p_q;
   logic [OPW-1:0] b_q;
   logic          b_zero;

   assign b_zero = (b_q == '0);

   shadd_ctrl u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (start),
      .b_zero (b_zero),
      .b_lsb  (b_q[0]),
      .st     (st),
      .ld_ops (ld_ops),
      .sh_ops (sh_ops),
      .psel   (psel),
      .ep     (ep),
      .done   (done)
   );

   shadd_shreg #(.W(PW), .GO_LEFT(1'b1)) u_areg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ld_ops),
      .shift (sh_ops),
      .din   ({{OPW{1'b0}}, op_a}),
      .q     (a_q)
   );

   shadd_shreg #(.W(OPW), .GO_LEFT(1'b0)) u_breg (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ld_ops),
      .shift (sh_ops),
      .din   (op_b),
      .q     (b_q)
   );

   shadd_accum #(.PW(PW)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .psel   (psel),
      .ep     (ep),
      .addend (a_q),
      .p      (p_q)
   );

   assign product = p_q;

   AST_IDLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_IDLE) |=> (product == '0)); // R2
   AST_B_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !b_zero) |=> (b_q == ($past(b_q) >> 1))); // R4
   AST_ACCUM: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !b_zero && b_q[0]) |=> (p_q == $past(p_q + a_q))); // R4
   AST_SKIP_ADD: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RUN && !b_zero && !b_q[0]) |=> $stable(p_q)); // R4
   AST_RESULT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(product)); // R6
endmodule

// File: tb/sim_shadd_mult.sv
module sim_shadd_mult;
   localparam int OPW = 8;
   localparam int PW  = 2 * OPW;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           start = 1'b0;
   logic [OPW-1:0] op_a = '0;
   logic [OPW-1:0] op_b = '0;
   logic [PW-1:0]  product;
   logic           done;

   int cmp_cnt = 0;
   int mis_cnt = 0;
   int cyc = 0;
   bit finished = 1'b0;

   // behavioural model: 0 idle, 1 compute, 2 done
   int     m_st = 0;
   longint m_a = 0, m_b = 0, m_p = 0;

   always #5 clk = ~clk;

   shadd_mult #(.OPW(OPW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start),
      .op_a(op_a), .op_b(op_b), .product(product), .done(done)
   );

   task automatic chk(input string tag, input longint act, input longint exp);
      cmp_cnt++;
      if (act != exp) begin
         mis_cnt++;
         $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_a = 0; m_b = 0; m_p = 0;
      end else begin
         case (m_st)
            0: begin
               m_p = 0;
               if (start) m_st = 1;
               else begin m_a = op_a; m_b = op_b; end
            end
            1: begin
               if (m_b == 0) m_st = 2;
               else begin
                  if (m_b % 2 == 1) m_p = m_p + m_a;
                  m_a = m_a * 2;
                  m_b = m_b / 2;
               end
            end
            default: if (!start) m_st = 0;
         endcase
      end
   end

   // per-clock comparison
   always @(negedge clk) begin
      string tag;
      cyc++;
      if (!rst_n) tag = "R1";
      else if (m_st == 0) tag = "R2";
      else if (m_st == 1) tag = "R4";
      else tag = start ? "R7" : "R6";
      chk({tag, " product"}, longint'(product), m_p);
      chk({tag, " done"}, longint'(done), (m_st == 2) ? 1 : 0);
      if (cyc > 150000 && !finished) begin
         finished = 1'b1;
         mis_cnt++;
         $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, mis_cnt);
         $finish;
      end
   end

   function automatic int exp_lat(input longint b);
      int k = 0;
      for (int i = 0; i < OPW; i++) if (b[i]) k = i + 1;
      return k + 2;
   endfunction

   task automatic run_op(input logic [OPW-1:0] a, input logic [OPW-1:0] b,
                         input string tag, input int hold);
      int lat = 0;
      @(negedge clk);
      op_a = a; op_b = b; start = 1'b0;
      @(negedge clk);
      start = 1'b1;
      // scramble inputs while computing: must be ignored (R3)
      op_a = ~a; op_b = b ^ 8'h5A;
      do begin
         @(negedge clk);
         lat++;
         op_a = op_a + 8'd37; op_b = op_b - 8'd11;
      end while (!done && lat < 40);
      chk("R5 latency", lat, exp_lat(b));
      chk({tag, " result"}, longint'(product), longint'(a) * longint'(b));
      repeat (hold) begin
         @(negedge clk);
         chk("R7 hold", longint'(done), 1);
         chk("R6 stable", longint'(product), longint'(a) * longint'(b));
      end
      start = 1'b0;
      @(negedge clk);
      chk("R7 leave", longint'(done), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset product", longint'(product), 0);
      chk("R1 reset done", longint'(done), 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      run_op(8'd13, 8'd11, "R8", 2);
      run_op(8'd0, 8'd0, "R9", 1);
      run_op(8'd255, 8'd0, "R9", 0);
      run_op(8'd0, 8'd255, "R9", 0);
      run_op(8'd255, 8'd255, "R9", 3);
      run_op(8'd1, 8'd128, "R6", 0);
      run_op(8'd200, 8'd1, "R6", 0);
      for (int i = 0; i < 40; i++) begin
         run_op(8'($urandom), 8'($urandom), "R6", i % 3);
      end
      // idle operand tracking without start (R2)
      repeat (4) begin
         @(negedge clk);
         op_a = 8'($urandom); op_b = 8'($urandom);
      end
      @(negedge clk);
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_cnt, mis_cnt);
      $finish;
   end
endmodule